// File: doc/BRIEF.md
# Battery Charge Ledger with Capacity Learning

This block keeps the charge books of a rechargeable pack. An available-charge counter rises with charge count strobes and falls with discharge and self-discharge strobes. It is capped at a learned full-capacity value. A separate discharge tally records how much has been drawn since the pack was last full. When a clean full-to-empty discharge has been observed, the first valid charge afterwards copies that tally into the learned capacity. The drop in any single update is limited to a quarter of the old value. The compensation arithmetic that produces the strobes is upstream and is not part of this block.

Two end-of-discharge monitors track the battery voltage. Comparators outside the block report when the voltage is below the first level and below the final level, which is 100 mV lower. Each monitor counts one-second ticks and latches its flag after a delay. The delay is chosen from how full the pack is and from a temperature band. Status flags record a qualified discharge, a replaced or reset pack, and active charging. A soft reset is recognised from a pair of writes: first 00h to the program register, then 00h to the capacity register.

Top module: `charge_ledger`

## Requirements
- R1: The available count increments on a charge strobe only while it is below the learned capacity. It decrements on discharge and self-discharge strobes only while it is above 0. After reset the available count is 0, the capacity is the programmed full count PFC, and the discharge tally is 0.
- R2: While the available count is above 0, discharge and self-discharge strobes each add 1 to the discharge tally. At 0, only discharge strobes add 1. The tally holds at FFFFh and reads 0 whenever the available count equals the capacity.
- R3: A cycle with `done_i` high makes the available count equal to the capacity and sets the qualified-discharge flag.
- R4: The qualified-discharge flag sets on a discharge strobe taken while the count equals the capacity. It clears on a valid charge. It clears once self-discharge strobes since it was set exceed 6% of the capacity at that time (count × 50 > base × 3). It also clears when the first end-of-discharge flag sets while `cold_i` is high.
- R5: A charge is valid on its third consecutive charge strobe; a done, discharge or self-discharge strobe breaks the run. `chg_active_o` is high from that strobe until the run is broken. If the first end-of-discharge flag is set at that strobe, the available count becomes 0. If the qualified flag is also set, the capacity becomes max(tally, capacity − floor(capacity/4)).
- R6: The valid-charge strobe clears both end-of-discharge flags.
- R7: An end-of-discharge flag sets on the tick that completes its delay while its comparator input stays high. The delay is counted in ticks of `sec_tick_i`. Above 40% full, the delay is 7, 6 or 5 ticks for temperature bands 0, 1 and 2–3. Between 20% and 40% full, it is 4, 3 or 2 ticks. Below 20% full, it is always 2. A low comparator input or a high `ovld_i` restarts the count. The flag stays latched until cleared.
- R8: A write of 00h to the program register, followed by a write of 00h to the capacity register with no other write between, is a soft reset. A soft reset sets the capacity to PFC, clears the count, the tally, the qualified flag and both end-of-discharge flags, and sets the replaced flag. Any other write pattern leaves all state unchanged.
- R9: The replaced flag clears when a charge strobe within a valid charge brings the count equal to the capacity. It also clears on the valid-charge strobe when the first end-of-discharge flag is set.
- R10: At most one strobe acts per clock. Priority is done, then charge, then discharge, then self-discharge. A soft reset overrides all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chg_i | input | 1 | Charge count strobe |
| dsg_i | input | 1 | Discharge count strobe |
| sdc_i | input | 1 | Self-discharge count strobe |
| done_i | input | 1 | Charge complete |
| vlow1_i | input | 1 | Battery voltage below first end-of-discharge level |
| vlow2_i | input | 1 | Battery voltage below final end-of-discharge level |
| ovld_i | input | 1 | Discharge overload active |
| cold_i | input | 1 | Temperature below 0 °C |
| temp_band_i | input | 2 | Temperature band: 0 below 10 °C, 1 from 10 to 30 °C, 2 or 3 above 30 °C |
| sec_tick_i | input | 1 | One-second tick |
| prog_wr_i | input | 1 | Write to the program register |
| cap_wr_i | input | 1 | Write to the capacity register |
| wr_data_i | input | 8 | Write data |
| nac_o | output | CW | Available charge count |
| dcr_o | output | CW | Discharge tally |
| lmd_o | output | CW | Learned capacity |
| vdq_o | output | 1 | Qualified-discharge flag |
| brp_o | output | 1 | Pack replaced / reset flag |
| edv1_o | output | 1 | First end-of-discharge flag |
| edvf_o | output | 1 | Final end-of-discharge flag |
| chg_active_o | output | 1 | Valid charge in progress |

## Verification
The assertions take the strobes as clean single-cycle qualified events. They also take `temp_band_i` and `cold_i` to be stable around a tick, and PFC to be nonzero, so that the capacity never reaches 0. The clamp and saturation properties also take for granted that no soft reset happens in the cycle being checked. The bench drives each input on the falling edge and holds it for whole cycles. It keeps the comparators and the overload input steady across each tick sequence, and uses PFC = 40 so that full-to-empty cycles stay short.

// File: rtl/charge_ledger_pkg.sv
package charge_ledger_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_DONE,
    OP_CHG,
    OP_DSG,
    OP_SDC
  } ledger_op_e;

  typedef enum logic [1:0] {
    CAP_HIGH,
    CAP_MID,
    CAP_LOW
  } cap_band_e;

  function automatic logic [2:0] edv_delay(cap_band_e cb, logic [1:0] tb);
    logic [2:0] d;
    unique case (cb)
      CAP_HIGH: d = (tb == 2'd0) ? 3'd7 : (tb == 2'd1) ? 3'd6 : 3'd5;
      CAP_MID:  d = (tb == 2'd0) ? 3'd4 : (tb == 2'd1) ? 3'd3 : 3'd2;
      default:  d = 3'd2;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/ledger_rst_seq.sv
module ledger_rst_seq #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prog_wr_i,
  input  logic          cap_wr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          fire_o
);
  logic armed_q;
  logic zero_data;

  assign zero_data = (wr_data_i == '0);
  assign fire_o    = armed_q && cap_wr_i && !prog_wr_i && zero_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_q <= 1'b0;
    else if (prog_wr_i) armed_q <= zero_data;
    else if (cap_wr_i)  armed_q <= 1'b0;
  end

  a_r8_fire_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !armed_q);
  a_r8_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_wr_i && !armed_q) |-> !fire_o);
endmodule

// File: rtl/ledger_chg_qual.sv
module ledger_chg_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chg_i,
  input  logic brk_i,
  output logic evt_o,
  output logic valid_o,
  output logic active_o
);
  logic [1:0] run_q;

  assign evt_o    = chg_i && (run_q == 2'd2);
  assign valid_o  = chg_i && (run_q >= 2'd2);
  assign active_o = (run_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         run_q <= 2'd0;
    else if (brk_i)                      run_q <= 2'd0;
    else if (chg_i && run_q != 2'd3)     run_q <= run_q + 2'd1;
  end

  a_r5_evt_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o && !brk_i |=> !evt_o);
  a_r5_brk_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> !active_o);
endmodule

// File: rtl/ledger_edv_mon.sv
module ledger_edv_mon (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       below_i,
  input  logic       ovld_i,
  input  logic       tick_i,
  input  logic [2:0] delay_i,
  input  logic       clr_i,
  output logic       flag_o,
  output logic       set_o
);
  logic [2:0] cnt_q;
  logic       flag_q;
  logic       armed;
  logic       due;

  assign armed  = below_i && !ovld_i && !flag_q;
  assign due    = ({1'b0, cnt_q} + 4'd1) >= {1'b0, delay_i};
  assign set_o  = !clr_i && armed && tick_i && due;
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (!below_i || ovld_i) begin
      cnt_q  <= '0;
    end else if (set_o) begin
      cnt_q  <= '0;
      flag_q <= 1'b1;
    end else if (armed && tick_i) begin
      cnt_q  <= cnt_q + 3'd1;
    end
  end

  a_r7_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr_i |=> flag_q);
  a_r7_ovld_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovld_i && !flag_q |=> !flag_q);
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_q);
endmodule

// File: rtl/charge_ledger.sv
module charge_ledger
  import charge_ledger_pkg::*;
#(
  parameter int          CW  = 16,
  parameter int          DW  = 8,
  parameter logic [15:0] PFC = 16'd27136
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          chg_i,
  input  logic          dsg_i,
  input  logic          sdc_i,
  input  logic          done_i,
  input  logic          vlow1_i,
  input  logic          vlow2_i,
  input  logic          ovld_i,
  input  logic          cold_i,
  input  logic [1:0]    temp_band_i,
  input  logic          sec_tick_i,
  input  logic          prog_wr_i,
  input  logic          cap_wr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [CW-1:0] nac_o,
  output logic [CW-1:0] dcr_o,
  output logic [CW-1:0] lmd_o,
  output logic          vdq_o,
  output logic          brp_o,
  output logic          edv1_o,
  output logic          edvf_o,
  output logic          chg_active_o
);
  localparam int            NMON = 2;
  localparam int            EW   = CW + 3;
  localparam int            MW   = CW + 7;
  localparam logic [CW-1:0] SAT  = '1;
  localparam logic [CW-1:0] PFC_C = CW'(PFC);

  logic [CW-1:0] nac_q, dcr_q, lmd_q, base_q, acc_q;
  logic [CW-1:0] nac_n, dcr_n, lmd_n, base_n, acc_n;
  logic          vdq_q, brp_q, vdq_n, brp_n;

  ledger_op_e    op;
  cap_band_e     band;
  logic [2:0]    delay;
  logic          soft_fire;
  logic          evt, chg_valid;
  logic          brk;
  logic [NMON-1:0] below, flag, set;
  logic [CW-1:0] learn_floor, learn_val;
  logic [CW-1:0] acc_inc;

  always_comb begin
    if (done_i)     op = OP_DONE;
    else if (chg_i) op = OP_CHG;
    else if (dsg_i) op = OP_DSG;
    else if (sdc_i) op = OP_SDC;
    else            op = OP_IDLE;
  end

  assign brk = soft_fire || op == OP_DONE || op == OP_DSG || op == OP_SDC;

  ledger_rst_seq #(.DW(DW)) u_rst_seq (
    .clk_i, .rst_ni, .prog_wr_i, .cap_wr_i, .wr_data_i, .fire_o(soft_fire)
  );

  ledger_chg_qual u_chg_qual (
    .clk_i, .rst_ni,
    .chg_i   (op == OP_CHG && !soft_fire),
    .brk_i   (brk),
    .evt_o   (evt),
    .valid_o (chg_valid),
    .active_o(chg_active_o)
  );

  // band from fill ratio: >40% high, <20% low
  always_comb begin
    if (EW'(nac_q) * EW'(5) > EW'(lmd_q) * EW'(2)) band = CAP_HIGH;
    else if (EW'(nac_q) * EW'(5) < EW'(lmd_q))     band = CAP_LOW;
    else                                             band = CAP_MID;
  end
  assign delay = edv_delay(band, temp_band_i);

  assign below = {vlow2_i, vlow1_i};

  for (genvar g = 0; g < NMON; g++) begin : g_edv
    ledger_edv_mon u_mon (
      .clk_i, .rst_ni,
      .below_i(below[g]),
      .ovld_i,
      .tick_i (sec_tick_i),
      .delay_i(delay),
      .clr_i  (evt || soft_fire),
      .flag_o (flag[g]),
      .set_o  (set[g])
    );
  end

  assign learn_floor = lmd_q - (lmd_q >> 2);
  assign learn_val   = (dcr_q > learn_floor) ? dcr_q : learn_floor;
  assign acc_inc     = (acc_q == SAT) ? acc_q : acc_q + 1'b1;

  always_comb begin
    nac_n  = nac_q;
    dcr_n  = dcr_q;
    lmd_n  = lmd_q;
    vdq_n  = vdq_q;
    brp_n  = brp_q;
    base_n = base_q;
    acc_n  = acc_q;
    unique case (op)
      OP_DONE: begin
        nac_n  = lmd_q;
        vdq_n  = 1'b1;
        base_n = lmd_q;
        acc_n  = '0;
      end
      OP_CHG: begin
        if (evt && flag[0]) begin
          nac_n = '0;
          brp_n = 1'b0;
          if (vdq_q) lmd_n = learn_val;
        end else if (nac_q < lmd_q) begin
          nac_n = nac_q + 1'b1;
        end
        if (evt) vdq_n = 1'b0;
        if (chg_valid && nac_n == lmd_n) brp_n = 1'b0;
      end
      OP_DSG: begin
        if (nac_q == lmd_q && !vdq_q) begin
          vdq_n  = 1'b1;
          base_n = lmd_q;
          acc_n  = '0;
        end
        if (nac_q != '0)  nac_n = nac_q - 1'b1;
        if (dcr_q != SAT) dcr_n = dcr_q + 1'b1;
      end
      OP_SDC: begin
        if (nac_q != '0) begin
          nac_n = nac_q - 1'b1;
          if (dcr_q != SAT) dcr_n = dcr_q + 1'b1;
          if (vdq_q) begin
            acc_n = acc_inc;
            if (MW'(acc_inc) * MW'(50) > MW'(base_q) * MW'(3)) vdq_n = 1'b0;
          end
        end
      end
      default: ;
    endcase
    if (set[0] && cold_i) vdq_n = 1'b0;
    if (nac_n == lmd_n)   dcr_n = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nac_q  <= '0;
      dcr_q  <= '0;
      lmd_q  <= PFC_C;
      vdq_q  <= 1'b0;
      brp_q  <= 1'b1;
      base_q <= '0;
      acc_q  <= '0;
    end else if (soft_fire) begin
      nac_q  <= '0;
      dcr_q  <= '0;
      lmd_q  <= PFC_C;
      vdq_q  <= 1'b0;
      brp_q  <= 1'b1;
      base_q <= '0;
      acc_q  <= '0;
    end else begin
      nac_q  <= nac_n;
      dcr_q  <= dcr_n;
      lmd_q  <= lmd_n;
      vdq_q  <= vdq_n;
      brp_q  <= brp_n;
      base_q <= base_n;
      acc_q  <= acc_n;
    end
  end

  assign nac_o  = nac_q;
  assign dcr_o  = dcr_q;
  assign lmd_o  = lmd_q;
  assign vdq_o  = vdq_q;
  assign brp_o  = brp_q;
  assign edv1_o = flag[0];
  assign edvf_o = flag[1];

  a_r1_nac_capped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nac_q <= lmd_q);
  a_r2_dcr_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dcr_q == SAT && !soft_fire |=> dcr_q == SAT || dcr_q == '0);
  a_r3_done_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !soft_fire && !(set[0] && cold_i) |=> nac_q == lmd_q && vdq_q);
  a_r5_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_fire |=> (EW'(lmd_q) * EW'(4)) >= (EW'($past(lmd_q)) * EW'(3)));
  a_r8_soft: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_fire |=> lmd_q == PFC_C && nac_q == '0 && brp_q && !vdq_q);
  a_r10_chg_over_dsg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_i && dsg_i && !done_i && !soft_fire && !flag[0] |=> nac_q >= $past(nac_q));
endmodule

// File: tb/charge_ledger_test.sv
`timescale 1ns/1ps
module charge_ledger_test;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chg = 0, dsg = 0, sdc = 0, done = 0;
  logic vlow1 = 0, vlow2 = 0, ovld = 0, cold = 0, tick = 0;
  logic [1:0] tband = 2'd1;
  logic pwr = 0, cwr = 0;
  logic [7:0] wdata = 8'h00;
  logic [CW-1:0] nac, dcr, lmd;
  logic vdq, brp, edv1, edvf, chga;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  charge_ledger #(.CW(CW), .DW(8), .PFC(16'd40)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .chg_i(chg), .dsg_i(dsg), .sdc_i(sdc), .done_i(done),
    .vlow1_i(vlow1), .vlow2_i(vlow2), .ovld_i(ovld), .cold_i(cold),
    .temp_band_i(tband), .sec_tick_i(tick),
    .prog_wr_i(pwr), .cap_wr_i(cwr), .wr_data_i(wdata),
    .nac_o(nac), .dcr_o(dcr), .lmd_o(lmd), .vdq_o(vdq), .brp_o(brp),
    .edv1_o(edv1), .edvf_o(edvf), .chg_active_o(chga)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_chg(int n);
    for (int i = 0; i < n; i++) begin chg = 1; @(negedge clk); end
    chg = 0;
  endtask
  task automatic pulse_dsg(int n);
    for (int i = 0; i < n; i++) begin dsg = 1; @(negedge clk); end
    dsg = 0;
  endtask
  task automatic pulse_sdc(int n);
    for (int i = 0; i < n; i++) begin sdc = 1; @(negedge clk); end
    sdc = 0;
  endtask
  task automatic pulse_done();
    done = 1; @(negedge clk); done = 0;
  endtask
  task automatic pulse_tick(int n);
    for (int i = 0; i < n; i++) begin tick = 1; @(negedge clk); end
    tick = 0;
  endtask
  task automatic wr(bit to_prog, logic [7:0] d);
    pwr = to_prog; cwr = !to_prog; wdata = d; @(negedge clk);
    pwr = 0; cwr = 0; wdata = 8'h00;
  endtask

  task automatic t_reset();
    chk("R1 reset nac", nac, 0);
    chk("R1 reset lmd", lmd, 40);
    chk("R1 reset dcr", dcr, 0);
    chk("R8 reset brp", brp, 1);
    chk("R4 reset vdq", vdq, 0);
    chk("R7 reset edv1", edv1, 0);
  endtask

  task automatic t_fill();
    pulse_chg(45);
    chk("R1 charge capped", nac, 40);
    chk("R2 dcr zero at full", dcr, 0);
    chk("R9 brp cleared at full", brp, 0);
    chk("R5 charge active", chga, 1);
  endtask

  task automatic t_drain();
    pulse_dsg(1);
    chk("R4 vdq on first discharge", vdq, 1);
    chk("R1 nac dec", nac, 39);
    chk("R2 dcr inc", dcr, 1);
    chk("R5 run broken", chga, 0);
    pulse_dsg(39);
    chk("R1 nac empty", nac, 0);
    pulse_dsg(5);
    chk("R1 nac floor", nac, 0);
    chk("R2 dcr past empty", dcr, 45);
    pulse_sdc(3);
    chk("R2 self-discharge ignored at 0", dcr, 45);
  endtask

  task automatic t_edv_learn_up();
    vlow1 = 1; vlow2 = 1; tband = 2'd1;
    pulse_tick(1);
    chk("R7 edv1 not yet", edv1, 0);
    pulse_tick(1);
    chk("R7 edv1 after 2", edv1, 1);
    chk("R7 edvf after 2", edvf, 1);
    vlow1 = 0; vlow2 = 0;
    pulse_chg(2);
    chk("R1 nac before valid", nac, 2);
    pulse_chg(1);
    chk("R5 nac cleared", nac, 0);
    chk("R5 learned", lmd, 45);
    chk("R6 edv1 cleared", edv1, 0);
    chk("R6 edvf cleared", edvf, 0);
    chk("R4 vdq cleared by charge", vdq, 0);
  endtask

  task automatic t_learn_clamp();
    pulse_done();
    chk("R3 done nac", nac, 45);
    chk("R3 done vdq", vdq, 1);
    pulse_dsg(20);
    chk("R2 dcr 20", dcr, 20);
    vlow1 = 1; tband = 2'd2;
    pulse_tick(4);
    chk("R7 high band wait", edv1, 0);
    pulse_tick(1);
    chk("R7 high band 5", edv1, 1);
    vlow1 = 0;
    pulse_chg(3);
    chk("R5 clamp 25%", lmd, 34);
    chk("R5 nac 0", nac, 0);
  endtask

  task automatic t_cold();
    pulse_done();
    pulse_dsg(30);
    chk("R1 nac 4", nac, 4);
    cold = 1; vlow1 = 1;
    pulse_tick(2);
    chk("R7 low band 2", edv1, 1);
    chk("R4 cold clears vdq", vdq, 0);
    cold = 0; vlow1 = 0;
    pulse_chg(3);
    chk("R5 no learn", lmd, 34);
    chk("R5 nac 0 no learn", nac, 0);
  endtask

  task automatic t_selfdis();
    pulse_done();
    pulse_sdc(2);
    chk("R4 vdq under 6%", vdq, 1);
    chk("R2 sdc counts", dcr, 2);
    pulse_sdc(1);
    chk("R4 vdq over 6%", vdq, 0);
    chk("R1 nac 31", nac, 31);
  endtask

  task automatic t_ovld();
    ovld = 1; vlow1 = 1;
    pulse_tick(10);
    chk("R7 overload blocks", edv1, 0);
    ovld = 0; vlow1 = 0;
  endtask

  task automatic t_prio();
    done = 1; chg = 1; @(negedge clk); done = 0; chg = 0;
    chk("R10 done over charge", nac, 34);
    chg = 1; dsg = 1; @(negedge clk); chg = 0; dsg = 0;
    chk("R10 charge over discharge nac", nac, 34);
    chk("R10 charge over discharge dcr", dcr, 0);
  endtask

  task automatic t_soft();
    wr(1, 8'h05); wr(0, 8'h00);
    chk("R8 bad data ignored", lmd, 34);
    chk("R8 bad data nac", nac, 34);
    wr(1, 8'h00); wr(1, 8'h01); wr(0, 8'h00);
    chk("R8 broken sequence ignored", lmd, 34);
    wr(1, 8'h00); wr(0, 8'h00);
    chk("R8 soft lmd", lmd, 40);
    chk("R8 soft nac", nac, 0);
    chk("R8 soft brp", brp, 1);
    chk("R8 soft vdq", vdq, 0);
  endtask

  task automatic t_brp_edv();
    vlow1 = 1;
    pulse_tick(2);
    chk("R7 edv1 empty", edv1, 1);
    vlow1 = 0;
    pulse_chg(3);
    chk("R9 brp cleared after edv1", brp, 0);
    chk("R5 lmd kept", lmd, 40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_drain();
    t_edv_learn_up();
    t_learn_clamp();
    t_cold();
    t_selfdis();
    t_ovld();
    t_prio();
    t_soft();
    t_brp_edv();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule